// File: doc/BRIEF.md
# Adaptive Page-Close Queue Scanner

This block decides, for a memory controller that runs an adaptive open-page policy, whether a bank should stay open after the request at the head of a queue has been serviced. A `start` pulse carries the serviced request: its direction, rank, bank and row, plus the bank's current free time, its row-active-done time and the precharge delay. The block then reads the queue of the same direction through an indexed read port, one entry per clock. It begins with the entry after the head and classifies each entry against the serviced request.

The scan ends as soon as both a further row hit and a bank conflict have been seen, or when the last valid entry has been examined. The block then raises `done` for one cycle. It reports whether hits and conflicts were found. When conflicts exist but no further hits do, it raises `auto_pre`, which tells the controller to close the row in that bank, and it gives the bank's new free time. Queue storage and request scheduling stay outside the block.

Top module: `pgc_scan`

## Requirements
- R1: After reset, `busy`, `done`, `hit_found`, `conflict_found` and `auto_pre` are all 0.
- R2: `q_sel_wr` is latched at start as the inverse of `svc_is_rd` (0 = read queue, 1 = write queue). The entry count comes from `rd_count` or `wr_count` to match, and both stay fixed until the scan finishes.
- R3: The head entry (index 0) is never examined. The first index presented on `q_idx` in a scan is 1.
- R4: An entry is a hit when its rank, bank and row all equal the serviced request's. It is a conflict when rank and bank are equal and the row differs. An entry with a different rank or bank is neither.
- R5: One entry is examined per clock, and `q_idx` advances by exactly one each scanning cycle.
- R6: The scan stops after the entry that first makes both a hit and a conflict seen. With m the index of that entry, `done` is high in the (m+1)-th cycle after the start edge.
- R7: Without early stopping, indices 1 to count-1 are all examined and `done` follows count cycles after start. A count of 0 or 1 gives `done` one cycle after start, with no hit and no conflict.
- R8: `auto_pre` is high exactly in the `done` cycle when no hit and at least one conflict were found.
- R9: When `auto_pre` is high, `new_free_at` equals the larger of the free time and the row-active-done time, plus the precharge delay. Otherwise it equals the free time.
- R10: A `start` pulse that arrives while `busy` is high is ignored: the queue selection, the result and the timing of the running scan do not change.
- R11: `done` lasts one cycle. `hit_found`, `conflict_found` and `new_free_at` hold their values until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Serviced-request pulse, accepted when idle |
| svc_is_rd | input | 1 | Serviced request was a read |
| svc_rank | input | RANK_W | Serviced request rank |
| svc_bank | input | BANK_W | Serviced request bank |
| svc_row | input | ROW_W | Serviced request row |
| bank_free_at | input | TIME_W | Bank's current free time |
| bank_ras_done_at | input | TIME_W | Time the row-active minimum expires |
| t_rp | input | TIME_W | Precharge delay |
| rd_count | input | CNT_W | Valid entries in the read queue |
| wr_count | input | CNT_W | Valid entries in the write queue |
| q_sel_wr | output | 1 | Queue being read: 0 read, 1 write |
| q_idx | output | IDX_W | Entry index being read |
| q_rank | input | RANK_W | Rank of the entry at q_idx |
| q_bank | input | BANK_W | Bank of the entry at q_idx |
| q_row | input | ROW_W | Row of the entry at q_idx |
| busy | output | 1 | Scan in progress |
| done | output | 1 | One-cycle result pulse |
| hit_found | output | 1 | A further row hit is pending |
| conflict_found | output | 1 | A bank conflict is pending |
| auto_pre | output | 1 | Close the bank's row (valid with done) |
| new_free_at | output | TIME_W | Bank free time after the decision |

## Verification
On every cycle, the assertions check the index stepping and the skipped head, that the index stays below the latched count, that the selected queue does not change mid-scan, that done lasts one cycle, and that auto-precharge matches the result flags. The scan never continues once both kinds of entry are known. Whether the classification of individual entries is right, whether the scan length fits the hit and conflict positions, and what arithmetic gives the new free time can only be shown by the bench's scenarios. Those scenarios plant hits and conflicts at chosen positions and fill the unselected queue with decoys.

// File: rtl/pgc_pkg.sv
package pgc_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SCAN = 2'd1,
    ST_DONE = 2'd2
  } scan_state_t;

  // Same rank and bank as the reference
  function automatic logic same_bank(input logic [7:0] ra, input logic [7:0] rb,
                                     input logic [7:0] ba, input logic [7:0] bb);
    return (ra == rb) && (ba == bb);
  endfunction

  // Time at which a precharged bank is free again
  function automatic logic [63:0] closed_free_time(input logic [63:0] free_at,
                                                   input logic [63:0] ras_done,
                                                   input logic [63:0] rp);
    logic [63:0] later;
    later = (free_at > ras_done) ? free_at : ras_done;
    return later + rp;
  endfunction

endpackage

// File: rtl/pgc_cmp.sv
module pgc_cmp #(
  parameter int RANK_W = 2,
  parameter int BANK_W = 3,
  parameter int ROW_W  = 14
) (
  input  logic [RANK_W-1:0] ref_rank,
  input  logic [BANK_W-1:0] ref_bank,
  input  logic [ROW_W-1:0]  ref_row,
  input  logic [RANK_W-1:0] ent_rank,
  input  logic [BANK_W-1:0] ent_bank,
  input  logic [ROW_W-1:0]  ent_row,
  output logic              ent_hit,
  output logic              ent_conf
);
  logic bank_match;
  logic row_match;

  always_comb begin
    bank_match = pgc_pkg::same_bank(8'(ref_rank), 8'(ent_rank),
                                    8'(ref_bank), 8'(ent_bank));
    row_match  = (ref_row == ent_row);
    ent_hit    = bank_match && row_match;
    ent_conf   = bank_match && !row_match;
  end
endmodule

// File: rtl/pgc_ctrl.sv
module pgc_ctrl #(
  parameter int DEPTH = 32,
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             svc_is_rd,
  input  logic [CNT_W-1:0] rd_count,
  input  logic [CNT_W-1:0] wr_count,
  input  logic             both_seen,
  output logic             sel_wr,
  output logic [IDX_W-1:0] idx,
  output logic [CNT_W-1:0] cnt_lat,
  output logic             accept,
  output logic             in_scan,
  output logic             busy,
  output logic             done
);
  import pgc_pkg::*;

  scan_state_t state_q, state_d;
  logic [CNT_W-1:0] cnt_pick;
  logic             last_entry;
  logic             stop_now;

  always_comb begin
    accept     = start && (state_q == ST_IDLE);
    cnt_pick   = svc_is_rd ? rd_count : wr_count;
    last_entry = ({1'b0, idx} == (cnt_lat - CNT_W'(1)));
    in_scan    = (state_q == ST_SCAN);
    stop_now   = in_scan && (both_seen || last_entry);
    busy       = (state_q != ST_IDLE);
    done       = (state_q == ST_DONE);
  end

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (accept) state_d = (cnt_pick <= CNT_W'(1)) ? ST_DONE : ST_SCAN;
      ST_SCAN: if (stop_now) state_d = ST_DONE;
      ST_DONE: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      sel_wr  <= 1'b0;
      idx     <= '0;
      cnt_lat <= '0;
    end else begin
      state_q <= state_d;
      if (accept) begin
        sel_wr  <= !svc_is_rd;
        cnt_lat <= cnt_pick;
        idx     <= IDX_W'(1);
      end else if (in_scan && !stop_now) begin
        idx <= idx + IDX_W'(1);
      end
    end
  end
endmodule

// File: rtl/pgc_result.sv
module pgc_result #(
  parameter int RANK_W = 2,
  parameter int BANK_W = 3,
  parameter int ROW_W  = 14,
  parameter int TIME_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic              in_scan,
  input  logic              done,
  input  logic [RANK_W-1:0] svc_rank,
  input  logic [BANK_W-1:0] svc_bank,
  input  logic [ROW_W-1:0]  svc_row,
  input  logic [TIME_W-1:0] bank_free_at,
  input  logic [TIME_W-1:0] bank_ras_done_at,
  input  logic [TIME_W-1:0] t_rp,
  input  logic              ent_hit,
  input  logic              ent_conf,
  output logic [RANK_W-1:0] ref_rank,
  output logic [BANK_W-1:0] ref_bank,
  output logic [ROW_W-1:0]  ref_row,
  output logic              hit_r,
  output logic              conf_r,
  output logic              both_seen,
  output logic              auto_pre,
  output logic [TIME_W-1:0] new_free_at
);
  logic [TIME_W-1:0] free_q, ras_q, rp_q;
  logic [TIME_W-1:0] closed_time;
  logic              close_it;

  always_comb begin
    both_seen   = (hit_r || ent_hit) && (conf_r || ent_conf);
    close_it    = !hit_r && conf_r;
    auto_pre    = done && close_it;
    closed_time = TIME_W'(pgc_pkg::closed_free_time(64'(free_q), 64'(ras_q), 64'(rp_q)));
    new_free_at = close_it ? closed_time : free_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ref_rank <= '0;
      ref_bank <= '0;
      ref_row  <= '0;
      free_q   <= '0;
      ras_q    <= '0;
      rp_q     <= '0;
      hit_r    <= 1'b0;
      conf_r   <= 1'b0;
    end else if (accept) begin
      ref_rank <= svc_rank;
      ref_bank <= svc_bank;
      ref_row  <= svc_row;
      free_q   <= bank_free_at;
      ras_q    <= bank_ras_done_at;
      rp_q     <= t_rp;
      hit_r    <= 1'b0;
      conf_r   <= 1'b0;
    end else if (in_scan) begin
      hit_r  <= hit_r  || ent_hit;
      conf_r <= conf_r || ent_conf;
    end
  end
endmodule

// File: rtl/pgc_scan.sv
module pgc_scan #(
  parameter int DEPTH  = 32,
  parameter int RANK_W = 2,
  parameter int BANK_W = 3,
  parameter int ROW_W  = 14,
  parameter int TIME_W = 32,
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              svc_is_rd,
  input  logic [RANK_W-1:0] svc_rank,
  input  logic [BANK_W-1:0] svc_bank,
  input  logic [ROW_W-1:0]  svc_row,
  input  logic [TIME_W-1:0] bank_free_at,
  input  logic [TIME_W-1:0] bank_ras_done_at,
  input  logic [TIME_W-1:0] t_rp,
  input  logic [CNT_W-1:0]  rd_count,
  input  logic [CNT_W-1:0]  wr_count,
  output logic              q_sel_wr,
  output logic [IDX_W-1:0]  q_idx,
  input  logic [RANK_W-1:0] q_rank,
  input  logic [BANK_W-1:0] q_bank,
  input  logic [ROW_W-1:0]  q_row,
  output logic              busy,
  output logic              done,
  output logic              hit_found,
  output logic              conflict_found,
  output logic              auto_pre,
  output logic [TIME_W-1:0] new_free_at
);
  // Named internal events, visible to the bound checker
  logic              accept;
  logic              in_scan;
  logic              both_seen;
  logic              ent_hit;
  logic              ent_conf;
  logic [CNT_W-1:0]  cnt_lat;
  logic [RANK_W-1:0] ref_rank;
  logic [BANK_W-1:0] ref_bank;
  logic [ROW_W-1:0]  ref_row;

  pgc_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .svc_is_rd (svc_is_rd),
    .rd_count  (rd_count),
    .wr_count  (wr_count),
    .both_seen (both_seen),
    .sel_wr    (q_sel_wr),
    .idx       (q_idx),
    .cnt_lat   (cnt_lat),
    .accept    (accept),
    .in_scan   (in_scan),
    .busy      (busy),
    .done      (done)
  );

  pgc_cmp #(.RANK_W(RANK_W), .BANK_W(BANK_W), .ROW_W(ROW_W)) u_cmp (
    .ref_rank (ref_rank),
    .ref_bank (ref_bank),
    .ref_row  (ref_row),
    .ent_rank (q_rank),
    .ent_bank (q_bank),
    .ent_row  (q_row),
    .ent_hit  (ent_hit),
    .ent_conf (ent_conf)
  );

  pgc_result #(.RANK_W(RANK_W), .BANK_W(BANK_W), .ROW_W(ROW_W), .TIME_W(TIME_W)) u_res (
    .clk              (clk),
    .rst_n            (rst_n),
    .accept           (accept),
    .in_scan          (in_scan),
    .done             (done),
    .svc_rank         (svc_rank),
    .svc_bank         (svc_bank),
    .svc_row          (svc_row),
    .bank_free_at     (bank_free_at),
    .bank_ras_done_at (bank_ras_done_at),
    .t_rp             (t_rp),
    .ent_hit          (ent_hit),
    .ent_conf         (ent_conf),
    .ref_rank         (ref_rank),
    .ref_bank         (ref_bank),
    .ref_row          (ref_row),
    .hit_r            (hit_found),
    .conf_r           (conflict_found),
    .both_seen        (both_seen),
    .auto_pre         (auto_pre),
    .new_free_at      (new_free_at)
  );
endmodule

// File: rtl/pgc_chk.sv
module pgc_chk #(
  parameter int IDX_W = 5,
  parameter int CNT_W = 6
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_scan,
  input logic             busy,
  input logic             done,
  input logic             q_sel_wr,
  input logic [IDX_W-1:0] q_idx,
  input logic [CNT_W-1:0] cnt_lat,
  input logic             hit_found,
  input logic             conflict_found,
  input logic             auto_pre
);
  // R3: every scan opens at the entry after the head
  a_r3_skip_head: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(in_scan) |-> (q_idx == IDX_W'(1)));

  // R5: one entry per clock
  a_r5_idx_step: assert property (@(posedge clk) disable iff (!rst_n)
    (in_scan && $past(in_scan)) |-> (q_idx == $past(q_idx) + IDX_W'(1)));

  // R7: never reads past the last valid entry
  a_r7_in_bounds: assert property (@(posedge clk) disable iff (!rst_n)
    in_scan |-> ({1'b0, q_idx} < cnt_lat));

  // R6: scanning does not continue once both kinds are recorded
  a_r6_early_stop: assert property (@(posedge clk) disable iff (!rst_n)
    in_scan |-> !(hit_found && conflict_found));

  // R2, R10: queue selection frozen while busy
  a_r2_sel_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(q_sel_wr));

  // R8: auto-precharge only with done, and exactly when conflicts without hits
  a_r8_autopre_when: assert property (@(posedge clk) disable iff (!rst_n)
    auto_pre |-> (done && !hit_found && conflict_found));
  a_r8_autopre_must: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !hit_found && conflict_found) |-> auto_pre);

  // R11: done is a single-cycle pulse
  a_r11_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
endmodule

bind pgc_scan pgc_chk #(.IDX_W(IDX_W), .CNT_W(CNT_W)) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .in_scan        (in_scan),
  .busy           (busy),
  .done           (done),
  .q_sel_wr       (q_sel_wr),
  .q_idx          (q_idx),
  .cnt_lat        (cnt_lat),
  .hit_found      (hit_found),
  .conflict_found (conflict_found),
  .auto_pre       (auto_pre)
);

// File: tb/sim_pgc_scan.sv
module sim_pgc_scan;
  localparam int DEPTH = 32, RANK_W = 2, BANK_W = 3, ROW_W = 14, TIME_W = 32;
  localparam int IDX_W = $clog2(DEPTH);
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [RANK_W-1:0] S_RANK = 2'd1;
  localparam logic [BANK_W-1:0] S_BANK = 3'd2;
  localparam logic [ROW_W-1:0]  S_ROW  = 14'h123;

  typedef struct packed {
    logic        is_rd;
    logic [5:0]  cnt;
    logic [5:0]  hpos;   // 0 = no planted hit
    logic [5:0]  cpos;   // 0 = no planted conflict
    logic [15:0] free;
    logic [15:0] ras;
    logic [7:0]  trp;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 6'd0,  6'd0, 6'd0,  16'd100, 16'd50,  8'd7},
    '{1'b1, 6'd1,  6'd0, 6'd0,  16'd100, 16'd50,  8'd7},
    '{1'b1, 6'd5,  6'd0, 6'd3,  16'd100, 16'd150, 8'd7},
    '{1'b0, 6'd5,  6'd0, 6'd3,  16'd200, 16'd120, 8'd9},
    '{1'b1, 6'd6,  6'd2, 6'd4,  16'd300, 16'd10,  8'd5},
    '{1'b1, 6'd6,  6'd4, 6'd2,  16'd300, 16'd10,  8'd5},
    '{1'b1, 6'd8,  6'd3, 6'd0,  16'd40,  16'd90,  8'd3},
    '{1'b0, 6'd32, 6'd0, 6'd31, 16'd500, 16'd700, 8'd11},
    '{1'b1, 6'd32, 6'd0, 6'd0,  16'd60,  16'd70,  8'd2},
    '{1'b1, 6'd4,  6'd0, 6'd5,  16'd80,  16'd20,  8'd4},
    '{1'b0, 6'd7,  6'd6, 6'd1,  16'd90,  16'd95,  8'd6},
    '{1'b1, 6'd2,  6'd0, 6'd1,  16'd1000,16'd999, 8'd8}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic svc_is_rd = 1'b1;
  logic [TIME_W-1:0] free_at = '0, ras_at = '0, rp = '0;
  logic [CNT_W-1:0] rd_count = '0, wr_count = '0;
  logic q_sel_wr, busy, done, hit_found, conflict_found, auto_pre;
  logic [IDX_W-1:0] q_idx;
  logic [RANK_W-1:0] q_rank;
  logic [BANK_W-1:0] q_bank;
  logic [ROW_W-1:0] q_row;
  logic [TIME_W-1:0] new_free_at;
  vec_t cur = '0;

  int checks = 0;
  int fails = 0;

  always #2.5 clk = ~clk;

  pgc_scan u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .svc_is_rd(svc_is_rd),
    .svc_rank(S_RANK), .svc_bank(S_BANK), .svc_row(S_ROW),
    .bank_free_at(free_at), .bank_ras_done_at(ras_at), .t_rp(rp),
    .rd_count(rd_count), .wr_count(wr_count),
    .q_sel_wr(q_sel_wr), .q_idx(q_idx), .q_rank(q_rank), .q_bank(q_bank), .q_row(q_row),
    .busy(busy), .done(done), .hit_found(hit_found), .conflict_found(conflict_found),
    .auto_pre(auto_pre), .new_free_at(new_free_at)
  );

  // Queue model: the vector's queue holds planted entries, the other holds decoys.
  // Neutral entries differ in rank (even index) or bank (odd index): R4.
  always_comb begin
    int i;
    logic own;
    i = int'(q_idx);
    own = (q_sel_wr == !cur.is_rd);
    q_rank = S_RANK; q_bank = S_BANK; q_row = S_ROW;
    if (!own) begin
      if (i % 2 == 0) q_row = S_ROW ^ 14'h1;
    end else if (i == 0 || (cur.hpos != 0 && i == int'(cur.hpos))) begin
      q_row = S_ROW;
    end else if (cur.cpos != 0 && i == int'(cur.cpos)) begin
      q_row = S_ROW ^ 14'h2;
    end else if (i % 2 == 0) begin
      q_rank = S_RANK + 2'd1;
    end else begin
      q_bank = S_BANK + 3'd1;
    end
  end

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Pulse start, return cycles until done is seen (at negedges)
  task automatic run_scan(output int lat);
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    lat = 1;
    while (!done && lat < 100) begin
      @(negedge clk); lat++;
    end
  endtask

  task automatic load(input vec_t v);
    cur = v;
    svc_is_rd = v.is_rd;
    free_at = TIME_W'(v.free); ras_at = TIME_W'(v.ras); rp = TIME_W'(v.trp);
    rd_count = v.is_rd ? CNT_W'(v.cnt) : CNT_W'(DEPTH);
    wr_count = v.is_rd ? CNT_W'(DEPTH) : CNT_W'(v.cnt);
  endtask

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    int lat;
    logic e_hit, e_conf, e_ap;
    int m;
    logic [63:0] e_free, later;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 busy", busy, 0);
    check("R1 done", done, 0);
    check("R1 hit", hit_found, 0);
    check("R1 conflict", conflict_found, 0);
    check("R1 auto_pre", auto_pre, 0);
    rst_n = 1'b1;

    for (int k = 0; k < NV; k++) begin
      vec_t v;
      v = VECS[k];
      load(v);
      e_hit  = (v.hpos != 0) && (v.hpos < v.cnt);
      e_conf = (v.cpos != 0) && (v.cpos < v.cnt);
      if (v.cnt <= 1) m = 0;
      else if (e_hit && e_conf) m = (v.hpos > v.cpos) ? int'(v.hpos) : int'(v.cpos);
      else m = int'(v.cnt) - 1;
      e_ap = !e_hit && e_conf;
      later = (v.free > v.ras) ? 64'(v.free) : 64'(v.ras);
      e_free = e_ap ? later + 64'(v.trp) : 64'(v.free);
      run_scan(lat);
      check("R6/R7 latency", 64'(lat), 64'(m + 1));
      check("R2 queue select", q_sel_wr, !v.is_rd);
      check("R3/R4 hit", hit_found, e_hit);
      check("R4 conflict", conflict_found, e_conf);
      check("R8 auto_pre", auto_pre, e_ap);
      check("R9 new_free_at", 64'(new_free_at), e_free);
      @(negedge clk);
      check("R11 done pulse", done, 0);
      check("R11 hit held", hit_found, e_hit);
      check("R11 free held", 64'(new_free_at), e_free);
    end

    // R10: start while busy is ignored (long read scan, no hits or conflicts)
    load(VECS[8]);
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    repeat (5) @(negedge clk);
    svc_is_rd = 1'b0; free_at = 32'd9999; start = 1'b1;
    @(negedge clk); start = 1'b0;
    check("R10 selection kept", q_sel_wr, 0);
    lat = 7;
    while (!done && lat < 100) begin @(negedge clk); lat++; end
    check("R10 latency", 64'(lat), 64'd32);
    check("R10 hit", hit_found, 0);
    check("R10 conflict", conflict_found, 0);
    check("R10 free", 64'(new_free_at), 64'd60);
    @(negedge clk);
    check("R10 no restart", busy, 0);

    // R5: stepping is visible on q_idx
    load(VECS[6]);
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    check("R5 first idx", 64'(q_idx), 64'd1);
    @(negedge clk);
    check("R5 second idx", 64'(q_idx), 64'd2);
    repeat (10) @(negedge clk);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule